// File: doc/BRIEF.md
# LVDS 7:1 Pixel Slot Formatter

The block takes one 24-bit RGB pixel with its horizontal sync, vertical sync and data-enable flags per pixel period. It spreads the 27 bits over four LVDS data pairs, seven time slots per pair. It also produces the matching clock-pair pattern. Two 24 bpp bit layouts can be chosen. The first puts the colour MSBs on the fourth pair. The second puts the colour LSBs there. An 18 bpp mode sends only the upper six bits of each colour on the first three pairs and keeps the fourth pair at zero.

Everything runs on one clock that is seven times the pixel rate. An internal phase counter marks each pixel boundary with a strobe, `pixTick`. The pixel on the inputs is captured at the edge that ends a tick cycle. The block shows its slot words in parallel, one pixel period after capture. Each word is also loaded into a shift register at the next boundary and shifted out, slot T0 first, one slot per fast clock. Analog drivers, the PLL and raster timing are not part of the block.

Top module: `lvds_slot_formatter`

## Requirements
- R1: `pixTick` is high for exactly one fast-clock cycle in every seven, and the counter wraps to its first phase after each tick.
- R2: Slot T0 is bit 6 of each word and T6 is bit 0. Red is `pixRgb[23:16]`, green is `[15:8]` and blue is `[7:0]`. With `lsbOnY3`=0 and `mode18`=0, the slots T0..T6 hold: Y0 = R2 R1 R0 R3 R4 R5 G0; Y1 = G3 G2 G1 G4 G5 B0 B1; Y2 = B4 B3 B2 B5 HS VS DE; Y3 = G6 R7 R6 G7 B6 B7 0.
- R3: With `lsbOnY3`=1 and `mode18`=0, the slots T0..T6 hold: Y0 = R4 R3 R2 R5 R6 R7 G2; Y1 = G5 G4 G3 G6 G7 B2 B3; Y2 = B6 B5 B4 B7 HS VS DE; Y3 = G0 R1 R0 G1 B0 B1 0.
- R4: In every mode, Y2 slots T4, T5 and T6 hold the captured HS, VS and DE.
- R5: Slot T6 of Y3 is always 0.
- R6: With `mode18`=1, Y0..Y2 use the R3 layout whatever `lsbOnY3` is, and all seven Y3 slots are 0.
- R7: A pixel captured at a boundary edge appears on the parallel words for the next pixel period. It is loaded into the shift registers at the following boundary edge. It then leaves on `serY[p]` with T0 in the first fast cycle and one slot per cycle after that.
- R8: `serClk` repeats the pattern 1,1,0,0,0,1,1 over T0..T6, in step with the data slots.
- R9: After reset, all parallel words, `serY` and `serClk` are 0, and the first `pixTick` comes in the seventh fast cycle.
- R10: `lsbOnY3`, `mode18` and the pixel inputs are sampled only at the boundary edge. Changing them between boundaries leaves the words unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock, seven times the pixel rate |
| rstN | input | 1 | Asynchronous active-low reset |
| lsbOnY3 | input | 1 | 24 bpp layout select: 0 puts the MSBs on Y3, 1 puts the LSBs on Y3 |
| mode18 | input | 1 | 18 bpp operation; Y3 held at zero |
| pixRgb | input | 24 | Pixel: red [23:16], green [15:8], blue [7:0] |
| pixHs | input | 1 | Horizontal sync flag |
| pixVs | input | 1 | Vertical sync flag |
| pixDe | input | 1 | Data-enable flag |
| pixTick | output | 1 | Load strobe; the inputs are captured at the edge ending this cycle |
| wordY0 | output | 7 | Parallel slot word of pair Y0, bit 6 = T0 |
| wordY1 | output | 7 | Parallel slot word of pair Y1 |
| wordY2 | output | 7 | Parallel slot word of pair Y2 |
| wordY3 | output | 7 | Parallel slot word of pair Y3 |
| serY | output | 4 | Serial data bit per pair, bit p = pair Yp |
| serClk | output | 1 | Serial clock-pair pattern |

## Verification
Two things happen on the same boundary edge: a new pixel is captured into the parallel words, and the previous pixel's words are loaded into the shift registers. The bench drives two different pixels in back-to-back periods. In the period that follows, it checks that the parallel words show the second pixel while the seven serial slots show the first. A one-hot walk over all 27 input bits, done under both layouts, shows that each bit lands in its listed slot. A change to the format and mode inputs between boundaries is checked to leave the words unchanged.

// File: rtl/lsf_pkg.sv
package lsf_pkg;
  localparam int SLOTS   = 7;
  localparam int PAIRS   = 4;
  localparam int COLOR_W = 8;
  localparam int PIX_W   = 3 * COLOR_W;
  localparam int SRC_W   = PIX_W + 4;          // colours, HS, VS, DE, constant zero
  localparam int CODE_W  = $clog2(SRC_W);
  localparam logic [SLOTS-1:0] CLK_PATTERN = 7'b1100011;

  typedef struct packed {
    logic capture;   // take a new pixel into the holding register
    logic load;      // move the current words into the shift registers
  } lsfCtrl_t;

  // Source index codes: red n -> n, green n -> 8+n, blue n -> 16+n,
  // 24 HS, 25 VS, 26 DE, 27 constant zero.
  function automatic logic [CODE_W-1:0] slotSource(input logic lsbLayout,
                                                   input int pair, input int slot);
    int base;
    case (pair * SLOTS + slot)
      0: base = 2;   1: base = 1;   2: base = 0;   3: base = 3;
      4: base = 4;   5: base = 5;   6: base = 8;
      7: base = 11;  8: base = 10;  9: base = 9;   10: base = 12;
      11: base = 13; 12: base = 16; 13: base = 17;
      14: base = 20; 15: base = 19; 16: base = 18; 17: base = 21;
      18: base = 24; 19: base = 25; 20: base = 26;
      21: base = 14; 22: base = 7;  23: base = 6;  24: base = 15;
      25: base = 22; 26: base = 23; default: base = 27;
    endcase
    if (lsbLayout && base < PIX_W) begin
      // LSB layout: colour bits step up by two on Y0..Y2, down by six on Y3
      base = (pair == PAIRS - 1) ? base - 6 : base + 2;
    end
    return CODE_W'(base);
  endfunction
endpackage

// File: rtl/lsf_ctrl.sv
module lsf_ctrl
  import lsf_pkg::*;
#(
  parameter int NUM_SLOTS = SLOTS
) (
  input  logic     clk,
  input  logic     rstN,
  output lsfCtrl_t ctrl,
  output logic     pixTick
);
  localparam int PHASE_W = $clog2(NUM_SLOTS);
  localparam logic [PHASE_W-1:0] LAST_PHASE = PHASE_W'(NUM_SLOTS - 1);

  logic [PHASE_W-1:0] phase;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                    phase <= '0;
    else if (phase == LAST_PHASE) phase <= '0;
    else                          phase <= phase + 1'b1;
  end

  assign pixTick      = (phase == LAST_PHASE);
  assign ctrl.capture = pixTick;
  assign ctrl.load    = pixTick;

  AST_PHASE_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    phase <= LAST_PHASE);                                       // R1
  AST_TICK_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    $past(pixTick) |-> (phase == '0));                          // R1
  AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    pixTick |=> !pixTick);                                      // R1
endmodule

// File: rtl/lsf_datapath.sv
module lsf_datapath
  import lsf_pkg::*;
(
  input  logic                         clk,
  input  logic                         rstN,
  input  lsfCtrl_t                     ctrl,
  input  logic                         lsbOnY3,
  input  logic                         mode18,
  input  logic [PIX_W-1:0]             pixRgb,
  input  logic                         pixHs,
  input  logic                         pixVs,
  input  logic                         pixDe,
  output logic [PAIRS-1:0][SLOTS-1:0]  wordY,
  output logic [PAIRS-1:0]             serY,
  output logic                         serClk
);
  logic [PIX_W-1:0] pixReg;
  logic             hsReg, vsReg, deReg, lsbReg, m18Reg;
  logic [SRC_W-1:0] srcVec;
  logic [PAIRS-1:0][SLOTS-1:0] shiftY;
  logic [SLOTS-1:0] shiftClk;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pixReg <= '0; hsReg <= 1'b0; vsReg <= 1'b0; deReg <= 1'b0;
      lsbReg <= 1'b0; m18Reg <= 1'b0;
    end else if (ctrl.capture) begin
      pixReg <= pixRgb; hsReg <= pixHs; vsReg <= pixVs; deReg <= pixDe;
      lsbReg <= lsbOnY3; m18Reg <= mode18;
    end
  end

  assign srcVec = {1'b0, deReg, vsReg, hsReg,
                   pixReg[COLOR_W-1:0],             // blue
                   pixReg[2*COLOR_W-1:COLOR_W],     // green
                   pixReg[PIX_W-1:2*COLOR_W]};      // red

  for (genvar p = 0; p < PAIRS; p++) begin : g_pair
    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
      localparam logic [CODE_W-1:0] CODE_M = slotSource(1'b0, p, s);
      localparam logic [CODE_W-1:0] CODE_L = slotSource(1'b1, p, s);
      if (p == PAIRS - 1) begin : g_last
        assign wordY[p][SLOTS-1-s] = m18Reg ? 1'b0 : srcVec[lsbReg ? CODE_L : CODE_M];
      end else begin : g_main
        assign wordY[p][SLOTS-1-s] = srcVec[(lsbReg || m18Reg) ? CODE_L : CODE_M];
      end
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)          shiftY[p] <= '0;
      else if (ctrl.load) shiftY[p] <= wordY[p];
      else                shiftY[p] <= {shiftY[p][SLOTS-2:0], 1'b0};
    end
    assign serY[p] = shiftY[p][SLOTS-1];

    AST_SER_FIRST_SLOT: assert property (@(posedge clk) disable iff (!rstN)
      $past(ctrl.load) |-> (serY[p] == $past(wordY[p][SLOTS-1])));   // R7
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          shiftClk <= '0;
    else if (ctrl.load) shiftClk <= CLK_PATTERN;
    else                shiftClk <= {shiftClk[SLOTS-2:0], 1'b0};
  end
  assign serClk = shiftClk[SLOTS-1];

  AST_CTRL_SLOTS: assert property (@(posedge clk) disable iff (!rstN)
    $past(ctrl.capture) |-> (wordY[2][2:0] == {$past(pixHs), $past(pixVs), $past(pixDe)})); // R4
  AST_Y3_LAST_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    wordY[PAIRS-1][0] == 1'b0);                                   // R5
  AST_Y3_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    $past(ctrl.capture && mode18) |-> (wordY[PAIRS-1] == '0));    // R6
  AST_CLK_EDGE: assert property (@(posedge clk) disable iff (!rstN)
    $past(ctrl.load) |-> serClk);                                 // R8
  AST_WORD_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !$past(ctrl.capture) |-> $stable(wordY));                     // R10
endmodule

// File: rtl/lvds_slot_formatter.sv
module lvds_slot_formatter
  import lsf_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        lsbOnY3,
  input  logic        mode18,
  input  logic [23:0] pixRgb,
  input  logic        pixHs,
  input  logic        pixVs,
  input  logic        pixDe,
  output logic        pixTick,
  output logic [6:0]  wordY0,
  output logic [6:0]  wordY1,
  output logic [6:0]  wordY2,
  output logic [6:0]  wordY3,
  output logic [3:0]  serY,
  output logic        serClk
);
  lsfCtrl_t ctrl;
  logic [PAIRS-1:0][SLOTS-1:0] wordY;

  lsf_ctrl #(.NUM_SLOTS(SLOTS)) u_ctrl (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .pixTick(pixTick));

  lsf_datapath u_dp (
    .clk(clk), .rstN(rstN), .ctrl(ctrl),
    .lsbOnY3(lsbOnY3), .mode18(mode18),
    .pixRgb(pixRgb), .pixHs(pixHs), .pixVs(pixVs), .pixDe(pixDe),
    .wordY(wordY), .serY(serY), .serClk(serClk));

  assign wordY0 = wordY[0];
  assign wordY1 = wordY[1];
  assign wordY2 = wordY[2];
  assign wordY3 = wordY[3];
endmodule

// File: tb/sim_lvds_slot_formatter.sv
module sim_lvds_slot_formatter;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic lsbOnY3 = 1'b0, mode18 = 1'b0, pixHs = 1'b0, pixVs = 1'b0, pixDe = 1'b0;
  logic [23:0] pixRgb = '0;
  logic pixTick, serClk;
  logic [6:0] wordY0, wordY1, wordY2, wordY3;
  logic [3:0] serY;
  int checks = 0;
  int fails = 0;

  always #5 clk = ~clk;

  lvds_slot_formatter u0 (
    .clk(clk), .rstN(rstN), .lsbOnY3(lsbOnY3), .mode18(mode18),
    .pixRgb(pixRgb), .pixHs(pixHs), .pixVs(pixVs), .pixDe(pixDe),
    .pixTick(pixTick), .wordY0(wordY0), .wordY1(wordY1), .wordY2(wordY2),
    .wordY3(wordY3), .serY(serY), .serClk(serClk));

  // vector fields: {mode18, lsbOnY3, de, vs, hs, rgb}
  localparam int NVEC = 8;
  localparam logic [28:0] VECS [NVEC] = '{
    {2'b00, 3'b101, 24'hA5C33C},
    {2'b00, 3'b010, 24'hFFFFFF},
    {2'b01, 3'b110, 24'h123456},
    {2'b01, 3'b001, 24'h80FE01},
    {2'b10, 3'b111, 24'hDEADBE},
    {2'b11, 3'b100, 24'h0F0F0F},
    {2'b00, 3'b000, 24'h000000},
    {2'b01, 3'b111, 24'h55AA55}
  };

  // expected {Y0,Y1,Y2,Y3}, T0 at bit 6 of each word
  function automatic logic [27:0] expWords(logic [28:0] v);
    logic [7:0] r, g, b;
    logic hs, vs, de;
    logic [6:0] y0, y1, y2, y3;
    r = v[23:16]; g = v[15:8]; b = v[7:0];
    hs = v[24]; vs = v[25]; de = v[26];
    if (v[28] || v[27]) begin
      y0 = {r[4], r[3], r[2], r[5], r[6], r[7], g[2]};
      y1 = {g[5], g[4], g[3], g[6], g[7], b[2], b[3]};
      y2 = {b[6], b[5], b[4], b[7], hs, vs, de};
      y3 = v[28] ? 7'd0 : {g[0], r[1], r[0], g[1], b[0], b[1], 1'b0};
    end else begin
      y0 = {r[2], r[1], r[0], r[3], r[4], r[5], g[0]};
      y1 = {g[3], g[2], g[1], g[4], g[5], b[0], b[1]};
      y2 = {b[4], b[3], b[2], b[5], hs, vs, de};
      y3 = {g[6], r[7], r[6], g[7], b[6], b[7], 1'b0};
    end
    return {y0, y1, y2, y3};
  endfunction

  function automatic string layoutTag(logic [28:0] v);
    return v[28] ? "R6" : (v[27] ? "R3" : "R2");
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(logic [28:0] v);
    {mode18, lsbOnY3, pixDe, pixVs, pixHs, pixRgb} = v;
  endtask

  // precondition: at a negedge with pixTick high. Returns at the next such negedge.
  task automatic toTick();
    @(negedge clk);
    while (!pixTick) @(negedge clk);
  endtask

  // collect seven serial slots; starts just after a load edge, ends at a tick negedge
  task automatic grabSerial(output logic [27:0] dat, output logic [6:0] ck);
    logic [6:0] s0, s1, s2, s3;
    for (int s = 0; s < 7; s++) begin
      @(negedge clk);
      s0[6-s] = serY[0]; s1[6-s] = serY[1]; s2[6-s] = serY[2]; s3[6-s] = serY[3];
      ck[6-s] = serClk;
    end
    dat = {s0, s1, s2, s3};
  endtask

  // drives v at a tick negedge, checks parallel words, then the serial stream
  task automatic runVec(logic [28:0] v, logic checkSer);
    logic [27:0] sd;
    logic [6:0] ck;
    logic [27:0] ex;
    ex = expWords(v);
    drive(v);
    @(negedge clk);
    chk(layoutTag(v), {4'd0, wordY0, wordY1, wordY2, wordY3}, {4'd0, ex});
    chk("R4", {29'd0, wordY2[2:0]}, {29'd0, v[24], v[25], v[26]});
    chk("R5", {31'd0, wordY3[0]}, 32'd0);
    toTick();
    if (checkSer) begin
      grabSerial(sd, ck);
      chk("R7", {4'd0, sd}, {4'd0, ex});
      chk("R8", {25'd0, ck}, {25'd0, 7'b1100011});
      chk("R1", {31'd0, pixTick}, 32'd1);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [27:0] sd, exA;
    logic [6:0] ck;
    int cnt;
    repeat (3) @(negedge clk);
    // R9: reset state
    chk("R9", {4'd0, wordY0, wordY1, wordY2, wordY3}, 32'd0);
    chk("R9", {27'd0, serY, serClk}, 32'd0);
    rstN = 1'b1;
    cnt = 0;
    while (!pixTick) begin cnt++; @(negedge clk); end
    chk("R9", cnt, 6);

    // R1: tick period is seven fast cycles
    cnt = 0;
    @(negedge clk);
    while (!pixTick) begin cnt++; @(negedge clk); end
    chk("R1", cnt, 6);

    // table walk
    for (int i = 0; i < NVEC; i++) runVec(VECS[i], 1'b1);

    // R2/R3: one-hot walk over all 27 input bits in both 24 bpp layouts
    for (int f = 0; f < 2; f++) begin
      for (int b = 0; b < 27; b++) begin
        logic [26:0] oh;
        oh = 27'd1 << b;
        runVec({1'b0, f[0], oh}, 1'b0);
      end
    end

    // R6: 18 bpp ignores the layout bit
    runVec({2'b10, 3'b000, 24'hC0FFEE}, 1'b1);
    runVec({2'b11, 3'b000, 24'hC0FFEE}, 1'b1);

    // R10: inputs changed between boundaries have no effect on the words
    drive({2'b00, 3'b010, 24'h3C5A96});
    @(negedge clk);
    drive({2'b11, 3'b101, 24'hFFFFFF});
    @(negedge clk);
    @(negedge clk);
    exA = expWords({2'b00, 3'b010, 24'h3C5A96});
    chk("R10", {4'd0, wordY0, wordY1, wordY2, wordY3}, {4'd0, exA});
    toTick();

    // R7: back-to-back pixels, capture and load on the same edge
    drive({2'b00, 3'b111, 24'h13579B});
    exA = expWords({2'b00, 3'b111, 24'h13579B});
    toTick();
    drive({2'b01, 3'b000, 24'hECA864});
    grabSerial(sd, ck);
    chk("R7", {4'd0, sd}, {4'd0, exA});
    chk("R7", {4'd0, wordY0, wordY1, wordY2, wordY3},
        {4'd0, expWords({2'b01, 3'b000, 24'hECA864})});
    chk("R8", {25'd0, ck}, {25'd0, 7'b1100011});

    // R9: reset in mid-stream clears everything
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    chk("R9", {4'd0, wordY0, wordY1, wordY2, wordY3}, 32'd0);
    chk("R9", {27'd0, serY, serClk}, 32'd0);
    rstN = 1'b1;

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule